// File: doc/BRIEF.md
# Fixed-Timing Receive Sampling Timer

This block sets the receive sampling point and the receive bit numbering for a network-side line receiver running in fixed-timing mode. No timing is recovered from the line. The sample point and the bit count both come from the transmit timing generator. The block takes two inputs from that generator: the transmit phase counter, which counts master clocks inside a bit, and the transmit bit counter, which gives the bit position inside a frame. It outputs one sample strobe per bit period, the index of the uplink bit being sampled, and a pulse at the start of each receive frame.

On the line, the nominal sample moment is 5 master clocks ahead of each transmit data edge, which is where the phase counter returns to 0. This margin covers up to 3 clocks of early uplink data plus a 1-clock step in the downlink clock. A static delay value, in master clocks, moves the internal sample point later to make up for transformer, filter and driver delay. About 1 clock covers 100 ns. The sum is taken modulo the bit length. When the sum wraps, the strobe falls inside the next transmit bit but still belongs to the same uplink bit. Uplink bit positions lag the transmit counter by two.

Top module: `rx_fix_timer`

## Requirements
- R1: While rst_ni is low, sample_o and rx_frame_o are 0 and rx_bit_o is 0.
- R2: sample_o is high for exactly one clock. That clock directly follows the clock in which tx_phase_i equals (35 + dly_i) mod 40. This gives one strobe per 40-clock bit period.
- R3: With dly_i = 0, the strobe follows tx_phase_i = 35, which is 5 clocks before the transmit edge at phase 0.
- R4: A non-zero dly_i moves the strobe later by dly_i clocks. When 35 + dly_i reaches 40 or more, the target phase wraps to 35 + dly_i - 40.
- R5: On a strobe with no phase wrap, rx_bit_o takes the value (tx_bit_i - 2) mod 48, where tx_bit_i is the value sampled in the clock before the strobe.
- R6: On a strobe whose target phase wrapped, rx_bit_o takes the value (tx_bit_i - 3) mod 48, so the index names the same uplink bit as it would without the wrap.
- R7: rx_bit_o changes only in a clock where sample_o is high.
- R8: rx_frame_o is high only together with a strobe that moves rx_bit_o from 47 to 0. It is low at every other time.
- R9: The index wraps correctly at the bottom of the frame: tx_bit_i values 0 and 1 give 46 and 47 without a wrap, and 0 gives 45 with a wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_phase_i | input | 6 | Transmit phase in the bit, 0..39; 0 is the data edge |
| tx_bit_i | input | 6 | Transmit bit position in the frame, 0..47 |
| dly_i | input | 4 | Internal delay compensation in master clocks, static |
| sample_o | output | 1 | Receive sample strobe |
| rx_bit_o | output | 6 | Index of the uplink bit being sampled, 0..47 |
| rx_frame_o | output | 1 | Receive frame start, with the strobe of index 0 |

## Verification
Two events can land in the same clock: the strobe whose compensated phase has wrapped into the next transmit bit, and the receive index turning over from 47 to 0. That strobe is sampled while the transmit bit counter has itself just wrapped. The bench provokes this with a delay of 5 and of 15 and with the transmit counters started close to the end of the frame. The strobe must still come once per bit. The index must still be the wrapped-back value, and the frame pulse must appear only on the strobe that gives index 0. The bench judges every clock against values it computes from the transmit counters it drives.

// File: rtl/rx_fix_pkg.sv
package rx_fix_pkg;
  localparam int unsigned BIT_CLKS   = 40;
  localparam int unsigned FRAME_BITS = 48;
  localparam int unsigned LEAD_CLKS  = 5;
  localparam int unsigned LAG_BITS   = 2;
  localparam int unsigned DLY_W      = 4;

  function automatic int unsigned width_of(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/rx_fix_phase.sv
module rx_fix_phase #(
  parameter int unsigned BIT_CLKS  = 40,
  parameter int unsigned LEAD_CLKS = 5,
  parameter int unsigned DLY_W     = 4,
  parameter int unsigned PH_W      = 6
) (
  input  logic [DLY_W-1:0] dly_i,
  output logic [PH_W-1:0]  target_o,
  output logic             late_o
);
  localparam int unsigned BASE  = BIT_CLKS - LEAD_CLKS;
  localparam int unsigned SUM_W = PH_W + 1;

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum    = SUM_W'(BASE) + SUM_W'(dly_i);
    late_o = (sum >= SUM_W'(BIT_CLKS));
    if (late_o) target_o = PH_W'(sum - SUM_W'(BIT_CLKS));
    else        target_o = PH_W'(sum);
  end
endmodule

// File: rtl/rx_fix_index.sv
module rx_fix_index #(
  parameter int unsigned FRAME_BITS = 48,
  parameter int unsigned LAG_BITS   = 2,
  parameter int unsigned BIT_W      = 6
) (
  input  logic [BIT_W-1:0] tx_bit_i,
  input  logic             late_i,
  output logic [BIT_W-1:0] idx_o
);
  localparam int unsigned S_W = BIT_W + 1;
  localparam bit POW2 = (FRAME_BITS == (1 << BIT_W));

  logic [S_W-1:0] s;

  // offset by a full frame so the subtraction never goes negative
  assign s = S_W'(tx_bit_i) + S_W'(FRAME_BITS - LAG_BITS) - S_W'(late_i);

  if (POW2) begin : g_mask
    assign idx_o = s[BIT_W-1:0];
  end else begin : g_fold
    always_comb begin
      if (s >= S_W'(FRAME_BITS)) idx_o = BIT_W'(s - S_W'(FRAME_BITS));
      else                       idx_o = BIT_W'(s);
    end
  end
endmodule

// File: rtl/rx_fix_track.sv
module rx_fix_track #(
  parameter int unsigned FRAME_BITS = 48,
  parameter int unsigned BIT_W      = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic [BIT_W-1:0] idx_i,
  output logic             sample_o,
  output logic [BIT_W-1:0] rx_bit_o,
  output logic             rx_frame_o
);
  logic             sample_q, frame_q;
  logic [BIT_W-1:0] idx_q;
  logic             wrap;

  assign wrap = (idx_q == BIT_W'(FRAME_BITS - 1)) && (idx_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_q <= 1'b0;
      frame_q  <= 1'b0;
      idx_q    <= '0;
    end else begin
      sample_q <= hit_i;
      frame_q  <= hit_i & wrap;
      if (hit_i) idx_q <= idx_i;
    end
  end

  assign sample_o   = sample_q;
  assign rx_bit_o   = idx_q;
  assign rx_frame_o = frame_q;
endmodule

// File: rtl/rx_fix_timer.sv
module rx_fix_timer
  import rx_fix_pkg::*;
#(
  parameter int unsigned BIT_CLKS   = rx_fix_pkg::BIT_CLKS,
  parameter int unsigned FRAME_BITS = rx_fix_pkg::FRAME_BITS,
  parameter int unsigned LEAD_CLKS  = rx_fix_pkg::LEAD_CLKS,
  parameter int unsigned LAG_BITS   = rx_fix_pkg::LAG_BITS,
  parameter int unsigned DLY_W      = rx_fix_pkg::DLY_W,
  localparam int unsigned PH_W      = width_of(BIT_CLKS),
  localparam int unsigned BIT_W     = width_of(FRAME_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PH_W-1:0]  tx_phase_i,
  input  logic [BIT_W-1:0] tx_bit_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             sample_o,
  output logic [BIT_W-1:0] rx_bit_o,
  output logic             rx_frame_o
);
  logic [PH_W-1:0]  target;
  logic             late;
  logic [BIT_W-1:0] idx_next;
  logic             hit;

  rx_fix_phase #(
    .BIT_CLKS(BIT_CLKS), .LEAD_CLKS(LEAD_CLKS), .DLY_W(DLY_W), .PH_W(PH_W)
  ) u_phase (
    .dly_i(dly_i), .target_o(target), .late_o(late)
  );

  rx_fix_index #(
    .FRAME_BITS(FRAME_BITS), .LAG_BITS(LAG_BITS), .BIT_W(BIT_W)
  ) u_index (
    .tx_bit_i(tx_bit_i), .late_i(late), .idx_o(idx_next)
  );

  assign hit = (tx_phase_i == target);

  rx_fix_track #(
    .FRAME_BITS(FRAME_BITS), .BIT_W(BIT_W)
  ) u_track (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit), .idx_i(idx_next),
    .sample_o(sample_o), .rx_bit_o(rx_bit_o), .rx_frame_o(rx_frame_o)
  );
endmodule

// File: rtl/rx_fix_chk.sv
module rx_fix_chk #(
  parameter int unsigned BIT_CLKS   = 40,
  parameter int unsigned FRAME_BITS = 48,
  parameter int unsigned LEAD_CLKS  = 5,
  parameter int unsigned DLY_W      = 4,
  parameter int unsigned PH_W       = 6,
  parameter int unsigned BIT_W      = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [PH_W-1:0]  tx_phase_i,
  input logic [DLY_W-1:0] dly_i,
  input logic             sample_o,
  input logic [BIT_W-1:0] rx_bit_o,
  input logic             rx_frame_o
);
  localparam int unsigned C_W = PH_W + 1;
  logic [C_W-1:0] want_c;
  logic [PH_W-1:0] want_ph;

  always_comb begin
    want_c  = C_W'(BIT_CLKS - LEAD_CLKS) + C_W'(dly_i);
    want_ph = (want_c >= C_W'(BIT_CLKS)) ? PH_W'(want_c - C_W'(BIT_CLKS)) : PH_W'(want_c);
  end

  a_r2_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !sample_o);

  a_r2_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> ($past(tx_phase_i) == $past(want_ph)));

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_o |-> $stable(rx_bit_o));

  a_r8_frame_on_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_frame_o |-> (sample_o && rx_bit_o == '0));

  a_r8_frame_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o && rx_bit_o == '0 && $past(rx_bit_o) == BIT_W'(FRAME_BITS - 1)) |-> rx_frame_o);

  a_r5_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_bit_o < BIT_W'(FRAME_BITS));
endmodule

bind rx_fix_timer rx_fix_chk #(
  .BIT_CLKS(BIT_CLKS), .FRAME_BITS(FRAME_BITS), .LEAD_CLKS(LEAD_CLKS),
  .DLY_W(DLY_W), .PH_W(PH_W), .BIT_W(BIT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tx_phase_i(tx_phase_i), .dly_i(dly_i),
  .sample_o(sample_o), .rx_bit_o(rx_bit_o), .rx_frame_o(rx_frame_o)
);

// File: tb/sim_rx_fix_timer.sv
module sim_rx_fix_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] tx_phase = '0;
  logic [5:0] tx_bit = '0;
  logic [3:0] dly = '0;
  logic       sample;
  logic [5:0] rx_bit;
  logic       rx_frame;

  int checks = 0;
  int errors = 0;
  int held   = 0;

  always #10 clk = ~clk;

  rx_fix_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .tx_phase_i(tx_phase), .tx_bit_i(tx_bit),
    .dly_i(dly), .sample_o(sample), .rx_bit_o(rx_bit), .rx_frame_o(rx_frame)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input int d, input int start_bit);
    @(negedge clk);
    rst_n = 1'b0; dly = 4'(d); tx_phase = '0; tx_bit = 6'(start_bit);
    repeat (2) @(negedge clk);
    chk(sample == 1'b0, "R1 sample", int'(sample), 0);
    chk(rx_frame == 1'b0, "R1 frame", int'(rx_frame), 0);
    chk(rx_bit == 6'd0, "R1 index", int'(rx_bit), 0);
    held = 0;
    rst_n = 1'b1;
  endtask

  // outputs at a negedge reflect the inputs held across the preceding posedge
  task automatic run(input int d, input int start_bit, input int nbits,
                     input string rs, input string ri);
    int tgt, late, frames;
    do_reset(d, start_bit);
    late = ((35 + d) >= 40) ? 1 : 0;
    tgt  = (35 + d) % 40;
    frames = 0;
    for (int c = 0; c < nbits * 40; c++) begin
      bit es, ef;
      int nidx;
      @(negedge clk);
      es = (int'(tx_phase) == tgt);
      ef = 1'b0;
      if (es) begin
        nidx = (int'(tx_bit) + 48 - 2 - late) % 48;
        ef = (nidx == 0) && (held == 47);
        held = nidx;
      end
      if (ef) frames++;
      chk(sample == es, rs, int'(sample), int'(es));
      chk(int'(rx_bit) == held, ri, int'(rx_bit), held);
      chk(rx_frame == ef, "R8 frame", int'(rx_frame), int'(ef));
      if (tx_phase == 6'd39) begin
        tx_phase = '0;
        tx_bit = (tx_bit == 6'd47) ? '0 : tx_bit + 6'd1;
      end else begin
        tx_phase = tx_phase + 6'd1;
      end
    end
    chk(frames >= 1 || nbits < 3, "R8 frame seen", frames, 1);
  endtask

  task automatic t_nominal;  run(0, 40, 20, "R3 strobe", "R5/R7 index"); endtask
  task automatic t_delay;    run(3, 42, 12, "R4 strobe", "R5/R7 index"); endtask
  task automatic t_wrap;     run(5, 44, 10, "R4 strobe", "R6 index");    endtask
  task automatic t_wrap_max; run(15, 45, 8, "R2 strobe", "R6/R9 index"); endtask
  task automatic t_low_bits; run(0, 46, 6, "R2 strobe", "R9 index");     endtask

  task automatic t_bottom;
    // wrapped delay at frame bottom: bit 0 must give index 45
    run(15, 0, 2, "R2 strobe", "R9 index");
    chk(held == 46, "R9 bottom", held, 46);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_nominal();
    t_delay();
    t_wrap();
    t_wrap_max();
    t_low_bits();
    t_bottom();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule